// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a free-running watchdog timer. Software controls it only through a small 32-bit register bus. Magic 16-bit values written to a key register do four things: they start the timer, they kick it (reload the count), they open the two configuration registers and they close them again. A 3-bit divider code picks how many clock cycles make one count step: 4 shifted left by the code, so 4 up to 256. A 12-bit reload value gives the starting point of a down-counter. When the counter runs out, the block pulses a reset request for one cycle. It then reloads itself, so it keeps expiring until it is kicked in time.

A new divider or reload value does not act at once. It is carried into the counting logic after a fixed, parameterised delay, which models a crossing into a slower clock domain. While the value is in transit, a status flag is raised for it. The count in progress keeps using the previously committed value until the flag drops. Once started, the timer can only be stopped by system reset. A window register sits at its offset and always reads its reset value.

The bus has no back-pressure. Every write is taken in the cycle it is presented. Read data is a combinational function of the address. The block has no streaming data path, so no valid/ready handshake is needed.

Top module: `kwdt_top`

## Requirements
- R1: After reset, the divider register reads 0, the reload register reads 0xFFF, status reads 0, the timer is stopped, the configuration registers are closed and `rst_req` is low.
- R2: Writes to the divider (offset 0x04) or reload (offset 0x08) register while they are closed leave the read-back value unchanged and raise no status flag.
- R3: A key write (offset 0x00) whose low 16 bits are 0x5555 opens the configuration registers. Any other key value closes them. Bits 31:16 of a key write are ignored.
- R4: An accepted divider write sets status bit 0 and an accepted reload write sets status bit 1, each from the next cycle on. The flag stays set for exactly SYNC_DELAY cycles. Until it clears, the counter keeps using the previously committed value.
- R5: Key 0xCCCC starts the timer. The first `rst_req` pulse arrives (reload+1) × (4 << code) cycles after the start write, and a code of 7 is treated as 6 (ratio 256).
- R6: Key 0xAAAA restarts a full period when the timer is running and has no effect while it is stopped. A stopped timer never raises `rst_req`.
- R7: `rst_req` is one cycle wide and repeats every full period while the timer is not kicked.
- R8: No key value stops a running timer, including 0x0000.
- R9: The window register (offset 0x10) always reads 0xFFF, and writes to it are ignored.
- R10: The key register reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and the counting logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, taken in the cycle it is high |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The hardest case to reach from the ports is a kick that lands while a reload update is still in transit. In that case the counter must reload from the old committed value and not from the newly written one. The stimulus sets up the smallest period, with reload 0 and divider 4. It then writes a larger reload value and issues the kick on the very next cycle. It checks that expiry still comes after 4 cycles. After the status flag has cleared, a second kick must give the longer period.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int unsigned OFS_KEY  = 'h00;
  localparam int unsigned OFS_DIV  = 'h04;
  localparam int unsigned OFS_RLD  = 'h08;
  localparam int unsigned OFS_STAT = 'h0C;
  localparam int unsigned OFS_WIN  = 'h10;

  localparam logic [15:0] KEY_OPEN  = 16'h5555;
  localparam logic [15:0] KEY_START = 16'hCCCC;
  localparam logic [15:0] KEY_KICK  = 16'hAAAA;

  localparam int unsigned MIN_SHIFT = 2;
  localparam int unsigned MAX_CODE  = 6;
  localparam int unsigned MAX_SHIFT = MIN_SHIFT + MAX_CODE;

  // Shift amount of the divide ratio; codes above MAX_CODE saturate.
  function automatic int unsigned div_shift(input int unsigned code);
    return MIN_SHIFT + ((code > MAX_CODE) ? MAX_CODE : code);
  endfunction
endpackage

// File: rtl/kwdt_xfer.sv
// Delayed commit of a configuration value into the counting logic.
module kwdt_xfer #(
  parameter int unsigned W          = 12,
  parameter int unsigned DELAY      = 5,
  parameter logic [W-1:0] RST_VAL   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         busy,
  output logic [W-1:0] dout
);
  localparam int unsigned CW = $clog2(DELAY + 1);
  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      left <= '0;
      dout <= RST_VAL;
    end else if (load) begin
      busy <= 1'b1;
      left <= CW'(DELAY);
    end else if (busy) begin
      if (left == CW'(1)) begin
        busy <= 1'b0;
        dout <= din;
      end
      left <= left - CW'(1);
    end
  end
endmodule

// File: rtl/kwdt_regs.sv
// Register bank with key decode and open/closed protection.
module kwdt_regs
  import kwdt_pkg::*;
#(
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DIV_W      = 3,
  parameter int unsigned RLD_W      = 12,
  parameter int unsigned SYNC_DELAY = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              start_hit,
  output logic              kick_hit,
  output logic              unlocked,
  output logic              div_busy,
  output logic              rld_busy,
  output logic [DIV_W-1:0]  div_eff,
  output logic [RLD_W-1:0]  rld_eff
);
  localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(OFS_KEY);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(OFS_DIV);
  localparam logic [ADDR_W-1:0] A_RLD  = ADDR_W'(OFS_RLD);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_WIN  = ADDR_W'(OFS_WIN);

  logic [DIV_W-1:0] div_reg;
  logic [RLD_W-1:0] rld_reg;
  logic             key_wr, div_ld, rld_ld;
  logic [15:0]      key;

  assign key       = bus_wdata[15:0];
  assign key_wr    = bus_wr && (bus_addr == A_KEY);
  assign start_hit = key_wr && (key == KEY_START);
  assign kick_hit  = key_wr && (key == KEY_KICK);
  assign div_ld    = bus_wr && (bus_addr == A_DIV) && unlocked;
  assign rld_ld    = bus_wr && (bus_addr == A_RLD) && unlocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      div_reg  <= '0;
      rld_reg  <= '1;
    end else begin
      if (key_wr) unlocked <= (key == KEY_OPEN);
      if (div_ld) div_reg <= bus_wdata[DIV_W-1:0];
      if (rld_ld) rld_reg <= bus_wdata[RLD_W-1:0];
    end
  end

  kwdt_xfer #(.W(DIV_W), .DELAY(SYNC_DELAY), .RST_VAL('0)) div_x_i (
    .clk(clk), .rst_n(rst_n), .load(div_ld), .din(div_reg),
    .busy(div_busy), .dout(div_eff));

  kwdt_xfer #(.W(RLD_W), .DELAY(SYNC_DELAY), .RST_VAL('1)) rld_x_i (
    .clk(clk), .rst_n(rst_n), .load(rld_ld), .din(rld_reg),
    .busy(rld_busy), .dout(rld_eff));

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_DIV:   bus_rdata[DIV_W-1:0] = div_reg;
      A_RLD:   bus_rdata[RLD_W-1:0] = rld_reg;
      A_STAT:  bus_rdata[1:0]       = {rld_busy, div_busy};
      A_WIN:   bus_rdata[RLD_W-1:0] = '1;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/kwdt_core.sv
// Divider and down-counter; runs from start until system reset.
module kwdt_core
  import kwdt_pkg::*;
#(
  parameter int unsigned DIV_W = 3,
  parameter int unsigned RLD_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             kick,
  input  logic [DIV_W-1:0] div_code,
  input  logic [RLD_W-1:0] rld_val,
  output logic             running,
  output logic             rst_req
);
  localparam int unsigned PW = MAX_SHIFT;

  logic [PW-1:0]    pre_cnt, pre_lim;
  logic [RLD_W-1:0] cnt;
  logic             step;

  assign pre_lim = {PW{1'b1}} >> (MAX_SHIFT - div_shift(int'(div_code)));
  assign step    = (pre_cnt >= pre_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      pre_cnt <= '0;
      cnt     <= '1;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (!running) begin
        if (start) begin
          running <= 1'b1;
          cnt     <= rld_val;
          pre_cnt <= '0;
        end
      end else if (kick) begin
        cnt     <= rld_val;
        pre_cnt <= '0;
      end else if (step) begin
        pre_cnt <= '0;
        if (cnt == '0) begin
          rst_req <= 1'b1;
          cnt     <= rld_val;
        end else begin
          cnt <= cnt - RLD_W'(1);
        end
      end else begin
        pre_cnt <= pre_cnt + PW'(1);
      end
    end
  end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top #(
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DIV_W      = 3,
  parameter int unsigned RLD_W      = 12,
  parameter int unsigned SYNC_DELAY = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req
);
  logic             start_hit, kick_hit, unlocked, running;
  logic             div_busy, rld_busy;
  logic [DIV_W-1:0] div_eff;
  logic [RLD_W-1:0] rld_eff;

  kwdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W),
              .RLD_W(RLD_W), .SYNC_DELAY(SYNC_DELAY)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .start_hit(start_hit),
    .kick_hit(kick_hit), .unlocked(unlocked), .div_busy(div_busy),
    .rld_busy(rld_busy), .div_eff(div_eff), .rld_eff(rld_eff));

  kwdt_core #(.DIV_W(DIV_W), .RLD_W(RLD_W)) core_i (
    .clk(clk), .rst_n(rst_n), .start(start_hit), .kick(kick_hit),
    .div_code(div_eff), .rld_val(rld_eff), .running(running),
    .rst_req(rst_req));
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker #(
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned SYNC_DELAY = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              rst_req,
  input logic              unlocked,
  input logic              running,
  input logic              div_busy
);
  logic div_acc, div_closed_wr, key_other;
  logic [15:0] run_len;

  assign div_acc       = bus_wr && (bus_addr == ADDR_W'('h04)) && unlocked;
  assign div_closed_wr = bus_wr && (bus_addr == ADDR_W'('h04)) && !unlocked;
  assign key_other     = bus_wr && (bus_addr == ADDR_W'('h00)) &&
                         (bus_wdata[15:0] != 16'h5555);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= '0;
    else if (div_acc) run_len <= 16'd1;
    else if (div_busy && run_len != 16'hFFFF) run_len <= run_len + 16'd1;
    else if (!div_busy) run_len <= '0;
  end

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  a_r6_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !rst_req);
  a_r8_no_stop: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);
  a_r4_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    div_acc |=> div_busy);
  a_r4_flag_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> (run_len <= 16'(SYNC_DELAY)));
  a_r2_closed_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (div_closed_wr && !div_busy) |=> !div_busy);
  a_r3_relock: assert property (@(posedge clk) disable iff (!rst_n)
    key_other |=> !unlocked);
  a_r9_window_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'('h10)) |-> (bus_rdata == DATA_W'('hFFF)));
endmodule

bind kwdt_top kwdt_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                             .SYNC_DELAY(SYNC_DELAY)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req),
  .unlocked(unlocked), .running(running), .div_busy(div_busy));

// File: tb/kwdt_top_tb_top.sv
module kwdt_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req;
  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;

  kwdt_top dut_i (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rst_req(rst_req));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: bench hung (actual %0d cycles, expected < 150000)", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output int d);
    bus_addr = a; #1; d = int'(bus_rdata);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Cycles until rst_req is seen high; 0 if not within lim.
  task automatic measure(input int lim, output int k);
    k = 0;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (rst_req) begin k = i; break; end
    end
  endtask

  task automatic t_reset();
    int d;
    rst_n = 1'b0; step(3); rst_n = 1'b1; step(1);
    rd(5'h04, d); chk("R1 divider reset", d, 0);
    rd(5'h08, d); chk("R1 reload reset", d, 'hFFF);
    rd(5'h0C, d); chk("R1 status reset", d, 0);
    chk("R1 rst_req low", int'(rst_req), 0);
    rd(5'h10, d); chk("R9 window reset", d, 'hFFF);
    rd(5'h00, d); chk("R10 key reads zero", d, 0);
  endtask

  task automatic t_closed();
    int d;
    wr(5'h04, 32'd5);
    rd(5'h0C, d); chk("R2 no flag on closed write", d, 0);
    rd(5'h04, d); chk("R2 divider unchanged", d, 0);
    wr(5'h08, 32'd7);
    rd(5'h08, d); chk("R2 reload unchanged", d, 'hFFF);
  endtask

  task automatic t_open_status();
    int d;
    wr(5'h00, 32'h5555);
    wr(5'h04, 32'd1);
    rd(5'h0C, d); chk("R4 divider flag set", d, 1);
    wr(5'h08, 32'd3);
    rd(5'h0C, d); chk("R4 both flags set", d, 3);
    step(3);
    rd(5'h0C, d); chk("R4 flags held", d, 3);
    step(1);
    rd(5'h0C, d); chk("R4 divider flag cleared after delay", d, 2);
    step(1);
    rd(5'h0C, d); chk("R4 reload flag cleared after delay", d, 0);
    rd(5'h04, d); chk("R3 divider written when open", d, 1);
    rd(5'h08, d); chk("R3 reload written when open", d, 3);
    wr(5'h00, 32'h1234);
    wr(5'h04, 32'd6);
    rd(5'h04, d); chk("R3 other key closes", d, 1);
    wr(5'h00, 32'h5555);
    wr(5'h10, 32'h55);
    rd(5'h10, d); chk("R9 window write ignored", d, 'hFFF);
    wr(5'h00, 32'h0000);
    step(10);
  endtask

  task automatic t_stopped();
    int k;
    wr(5'h00, 32'hAAAA);
    measure(300, k);
    chk("R6 kick while stopped gives no pulse", k, 0);
  endtask

  task automatic t_start();
    int k;
    wr(5'h00, 32'hCCCC);
    measure(100, k); chk("R5 first expiry (3+1)*8", k, 32);
    step(1); chk("R7 pulse one cycle wide", int'(rst_req), 0);
    measure(100, k); chk("R7 free-running repeat", k, 31);
  endtask

  task automatic t_kick();
    int k;
    step(10);
    wr(5'h00, 32'hABCD_AAAA);
    measure(100, k); chk("R6 kick restarts period, R3 upper key bits ignored", k, 32);
  endtask

  task automatic t_nostop();
    int k;
    wr(5'h00, 32'hAAAA);
    wr(5'h00, 32'h0000);
    measure(100, k); chk("R8 key 0x0000 does not stop", k, 31);
  endtask

  task automatic t_ratio();
    int k;
    wr(5'h00, 32'h5555);
    wr(5'h04, 32'd7);
    wr(5'h08, 32'd0);
    step(10);
    wr(5'h00, 32'hAAAA);
    measure(400, k); chk("R5 code 7 saturates to 256", k, 256);
    wr(5'h00, 32'h5555);
    wr(5'h04, 32'd0);
    step(10);
    wr(5'h00, 32'hAAAA);
    measure(100, k); chk("R5 minimum period 4", k, 4);
  endtask

  task automatic t_pending();
    int k;
    wr(5'h00, 32'h5555);
    wr(5'h08, 32'd2);
    wr(5'h00, 32'hAAAA);
    measure(100, k); chk("R4 kick uses old reload while pending", k, 4);
    step(10);
    wr(5'h00, 32'hAAAA);
    measure(100, k); chk("R4 new reload after commit", k, 12);
  endtask

  initial begin
    t_reset();
    t_closed();
    t_open_status();
    t_stopped();
    t_start();
    t_kick();
    t_nostop();
    t_ratio();
    t_pending();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule